// File: doc/BRIEF.md
# Segmented Program and Stack Bounds Checker

This unit guards memory traffic for a 16-bit stack-oriented processor whose code and data live in separate address spaces. It holds seven bound registers: program base, program limit, data base, data limit, stack limit, stack pointer and activation-record marker. Every requested operation (instruction fetch, data read, data write, push, pop, procedure mark, procedure return) is compared against these registers in the same cycle. The unit either grants the operation or raises exactly one fault flag naming the kind of violation. A faulting operation is blocked and leaves every register as it was.

A host port loads any bound register. Push and pop move the stack pointer by one word. A mark copies the stack pointer into the marker, and a return copies the marker back into the stack pointer. All register changes take effect on the next rising clock edge.

Top module: `seg_bounds_unit`

## Requirements
- R1: During and right after an active-low reset, the stack pointer and the marker read 0. The program base, data base and data limit are 0. The program limit and the stack limit are all ones. grant and all fault flags are 0 while op is idle.
- R2: When host_we is 1, host_wdata is loaded on the next edge into the register chosen by host_sel. The codes are 0 program base, 1 program limit, 2 data base, 3 data limit, 4 stack limit, 5 stack pointer and 6 marker. Code 7 loads nothing. In that cycle op is ignored: grant and all faults stay 0 and the stack pointer and marker do not change.
- R3: A fetch (op 1) is granted when program base ≤ pc ≤ program limit. Otherwise fault_prog is raised.
- R4: A push (op 4) is granted, and the stack pointer incremented, when stack pointer + 1 ≤ stack limit. This sum is computed without wrap-around. Otherwise fault_ovf is raised and the stack pointer holds.
- R5: A pop (op 5) raises fault_unf and holds the stack pointer when the stack pointer is below the marker or below the data base. Otherwise it is granted and the stack pointer decrements, wrapping modulo 2^16.
- R6: A data read (op 2) or write (op 3) is granted when data limit ≤ addr ≤ stack pointer. Otherwise fault_data is raised.
- R7: A mark (op 6) is granted and loads the marker with the current stack pointer.
- R8: A return (op 7) is granted and loads the stack pointer from the marker.
- R9: An idle op (op 0) gives no grant, no fault and no register change.
- R10: At most one fault flag is high in any cycle, and grant is never high together with a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register load strobe |
| host_sel | input | 3 | Register select for the host load |
| host_wdata | input | 16 | Value to load |
| op | input | 3 | Operation request code |
| pc | input | 16 | Program counter for fetch checks |
| addr | input | 16 | Data address for read and write checks |
| grant | output | 1 | Requested operation is allowed |
| fault_prog | output | 1 | Fetch outside the program bounds |
| fault_ovf | output | 1 | Push would exceed the stack limit |
| fault_unf | output | 1 | Pop below the marker or the data base |
| fault_data | output | 1 | Data access outside data limit to stack pointer |
| sp_out | output | 16 | Current stack pointer |
| sm_out | output | 16 | Current activation-record marker |

## Verification
The bench builds the unit with its default 16-bit address width. Most of its random bound and address values are drawn from a narrow window near zero, with the top two codes mixed in. This makes equality at each bound a frequent event. It also reaches the all-ones stack pointer, where a push must fault rather than wrap, and a pop from zero, where the pointer wraps. A behavioural model of all seven registers predicts grant, every fault and both pointers, and it is compared on every cycle.

// File: rtl/segb_pkg.sv
package segb_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_FETCH = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PUSH  = 3'd4,
        OP_POP   = 3'd5,
        OP_MARK  = 3'd6,
        OP_RET   = 3'd7
    } segb_op_e;

    typedef enum logic [2:0] {
        SEL_PBASE = 3'd0,
        SEL_PLIM  = 3'd1,
        SEL_DBASE = 3'd2,
        SEL_DLIM  = 3'd3,
        SEL_SLIM  = 3'd4,
        SEL_SPTR  = 3'd5,
        SEL_MARK  = 3'd6,
        SEL_NONE  = 3'd7
    } segb_sel_e;

    typedef struct packed {
        logic prog;
        logic ovf;
        logic unf;
        logic data;
    } segb_fault_t;

endpackage

// File: rtl/segb_check.sv
module segb_check
    import segb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  segb_op_e      op,
    input  logic          host_busy,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] pbase,
    input  logic [AW-1:0] plim,
    input  logic [AW-1:0] dbase,
    input  logic [AW-1:0] dlim,
    input  logic [AW-1:0] slim,
    input  logic [AW-1:0] sptr,
    input  logic [AW-1:0] mark,
    output segb_fault_t   fault,
    output logic          grant,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          do_mark,
    output logic          do_ret
);

    localparam int EW = AW + 1;

    logic [EW-1:0] sp_next_up;
    logic          in_prog;
    logic          in_data;
    logic          room_up;
    logic          below_floor;

    assign sp_next_up  = {1'b0, sptr} + EW'(1);
    assign in_prog     = (pc >= pbase) && (pc <= plim);
    assign in_data     = (addr >= dlim) && (addr <= sptr);
    assign room_up     = (sp_next_up <= {1'b0, slim});
    assign below_floor = (sptr < mark) || (sptr < dbase);

    always_comb begin
        fault   = '0;
        grant   = 1'b0;
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        do_mark = 1'b0;
        do_ret  = 1'b0;
        if (!host_busy) begin
            unique case (op)
                OP_IDLE: ;
                OP_FETCH: begin
                    grant      = in_prog;
                    fault.prog = !in_prog;
                end
                OP_READ, OP_WRITE: begin
                    grant      = in_data;
                    fault.data = !in_data;
                end
                OP_PUSH: begin
                    push_ok   = room_up;
                    grant     = room_up;
                    fault.ovf = !room_up;
                end
                OP_POP: begin
                    pop_ok    = !below_floor;
                    grant     = !below_floor;
                    fault.unf = below_floor;
                end
                OP_MARK: begin
                    do_mark = 1'b1;
                    grant   = 1'b1;
                end
                OP_RET: begin
                    do_ret = 1'b1;
                    grant  = 1'b1;
                end
            endcase
        end
    end

    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault)); // R10
    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (fault == '0)); // R10
    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> (!grant && fault == '0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |-> (!grant && fault == '0)); // R9

endmodule

// File: rtl/segb_regs.sv
module segb_regs
    import segb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  segb_sel_e     host_sel,
    input  logic [AW-1:0] host_wdata,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic          do_mark,
    input  logic          do_ret,
    input  logic          stack_fault,
    output logic [AW-1:0] pbase,
    output logic [AW-1:0] plim,
    output logic [AW-1:0] dbase,
    output logic [AW-1:0] dlim,
    output logic [AW-1:0] slim,
    output logic [AW-1:0] sptr,
    output logic [AW-1:0] mark
);

    localparam logic [AW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pbase <= '0;
            plim  <= TOP;
            dbase <= '0;
            dlim  <= '0;
            slim  <= TOP;
            sptr  <= '0;
            mark  <= '0;
        end else if (host_we) begin
            unique case (host_sel)
                SEL_PBASE: pbase <= host_wdata;
                SEL_PLIM:  plim  <= host_wdata;
                SEL_DBASE: dbase <= host_wdata;
                SEL_DLIM:  dlim  <= host_wdata;
                SEL_SLIM:  slim  <= host_wdata;
                SEL_SPTR:  sptr  <= host_wdata;
                SEL_MARK:  mark  <= host_wdata;
                SEL_NONE:  ;
            endcase
        end else begin
            if (push_ok)      sptr <= sptr + AW'(1);
            else if (pop_ok)  sptr <= sptr - AW'(1);
            else if (do_ret)  sptr <= mark;
            if (do_mark)      mark <= sptr;
        end
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (sptr == $past(sptr) + AW'(1))); // R4
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> (sptr == $past(sptr) - AW'(1))); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault |=> $stable(sptr)); // R4
    AST_MARK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        do_mark |=> (mark == $past(sptr))); // R7
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (sptr == $past(mark))); // R8

endmodule

// File: rtl/seg_bounds_unit.sv
module seg_bounds_unit
    import segb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [2:0]    host_sel,
    input  logic [AW-1:0] host_wdata,
    input  logic [2:0]    op,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] addr,
    output logic          grant,
    output logic          fault_prog,
    output logic          fault_ovf,
    output logic          fault_unf,
    output logic          fault_data,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] sm_out
);

    logic [AW-1:0] pbase, plim, dbase, dlim, slim, sptr, mark;
    segb_fault_t   fault;
    logic          push_ok, pop_ok, do_mark, do_ret;

    segb_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_sel    (segb_sel_e'(host_sel)),
        .host_wdata  (host_wdata),
        .push_ok     (push_ok),
        .pop_ok      (pop_ok),
        .do_mark     (do_mark),
        .do_ret      (do_ret),
        .stack_fault (fault.ovf | fault.unf),
        .pbase       (pbase),
        .plim        (plim),
        .dbase       (dbase),
        .dlim        (dlim),
        .slim        (slim),
        .sptr        (sptr),
        .mark        (mark)
    );

    segb_check #(.AW(AW)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (segb_op_e'(op)),
        .host_busy (host_we),
        .pc        (pc),
        .addr      (addr),
        .pbase     (pbase),
        .plim      (plim),
        .dbase     (dbase),
        .dlim      (dlim),
        .slim      (slim),
        .sptr      (sptr),
        .mark      (mark),
        .fault     (fault),
        .grant     (grant),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .do_mark   (do_mark),
        .do_ret    (do_ret)
    );

    assign fault_prog = fault.prog;
    assign fault_ovf  = fault.ovf;
    assign fault_unf  = fault.unf;
    assign fault_data = fault.data;
    assign sp_out     = sptr;
    assign sm_out     = mark;

endmodule

// File: tb/tb_seg_bounds_unit.sv
`timescale 1ns/1ps
module tb_seg_bounds_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [15:0] host_wdata = '0;
    logic [2:0]  op = '0;
    logic [15:0] pc = '0;
    logic [15:0] addr = '0;
    logic        grant, fault_prog, fault_ovf, fault_unf, fault_data;
    logic [15:0] sp_out, sm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_pb, m_pl, m_db, m_dl, m_sl, m_sp, m_sm;

    always #2 clk = ~clk;

    seg_bounds_unit dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .op(op), .pc(pc), .addr(addr),
        .grant(grant), .fault_prog(fault_prog), .fault_ovf(fault_ovf),
        .fault_unf(fault_unf), .fault_data(fault_data),
        .sp_out(sp_out), .sm_out(sm_out)
    );

    task automatic chk(input int act, input int exp, input string what, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int o, input bit hwe);
        if (hwe) return "R2";
        case (o)
            0: return "R9";
            1: return "R3";
            2, 3: return "R6";
            4: return "R4";
            5: return "R5";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic step(input int o, input int p, input int a,
                        input bit hwe, input int hs, input int hd);
        bit eg, ep, eo, eu, ed;
        string rq;
        @(negedge clk);
        op = 3'(o); pc = 16'(p); addr = 16'(a);
        host_we = hwe; host_sel = 3'(hs); host_wdata = 16'(hd);
        #1;
        eg = 0; ep = 0; eo = 0; eu = 0; ed = 0;
        rq = req_of(o, hwe);
        if (!hwe) begin
            case (o)
                1: begin eg = (m_pb <= p) && (p <= m_pl); ep = !eg; end
                2, 3: begin eg = (m_dl <= a) && (a <= m_sp); ed = !eg; end
                4: begin eg = (m_sp + 1 <= m_sl); eo = !eg; end
                5: begin eu = (m_sp < m_sm) || (m_sp < m_db); eg = !eu; end
                6, 7: eg = 1;
                default: ;
            endcase
        end
        chk(grant, eg, "grant", rq);
        chk(fault_prog, ep, "fault_prog", rq);
        chk(fault_ovf, eo, "fault_ovf", rq);
        chk(fault_unf, eu, "fault_unf", rq);
        chk(fault_data, ed, "fault_data", rq);
        chk(sp_out, m_sp, "sp_out", rq);
        chk(sm_out, m_sm, "sm_out", rq);
        // R10: never more than one fault, never grant with a fault
        chk(int'(fault_prog) + fault_ovf + fault_unf + fault_data + (grant ? 4 : 0) > 4 ||
            (int'(fault_prog) + fault_ovf + fault_unf + fault_data > 1), 0, "fault exclusivity", "R10");
        if (hwe) begin
            case (hs)
                0: m_pb = hd;
                1: m_pl = hd;
                2: m_db = hd;
                3: m_dl = hd;
                4: m_sl = hd;
                5: m_sp = hd;
                6: m_sm = hd;
                default: ;
            endcase
        end else begin
            case (o)
                4: if (eg) m_sp = m_sp + 1;
                5: if (eg) m_sp = (m_sp - 1) & 16'hFFFF;
                6: m_sm = m_sp;
                7: m_sp = m_sm;
                default: ;
            endcase
        end
    endtask

    function automatic int pick();
        int r = $urandom_range(0, 15);
        if (r == 14) return 16'hFFFF;
        if (r == 15) return 16'hFFFE;
        return $urandom_range(0, 12);
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pb = 0; m_pl = 16'hFFFF; m_db = 0; m_dl = 0;
        m_sl = 16'hFFFF; m_sp = 0; m_sm = 0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(sp_out, 0, "sp in reset", "R1");
        chk(sm_out, 0, "sm in reset", "R1");
        chk(grant, 0, "grant in reset", "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);           // R9 idle, R1 reset values
        step(1, 16'hFFFF, 0, 0, 0, 0);    // R1 program limit all ones -> R3 grant
        step(0, 0, 0, 1, 1, 10);          // R2 program limit = 10
        step(1, 11, 0, 0, 0, 0);          // R3 above limit
        step(1, 10, 0, 0, 0, 0);          // R3 at limit
        step(0, 0, 0, 1, 0, 3);           // program base = 3
        step(1, 2, 0, 0, 0, 0);           // R3 below base
        step(1, 3, 0, 0, 0, 0);           // R3 at base
        step(0, 0, 0, 1, 4, 2);           // stack limit = 2
        step(4, 0, 0, 0, 0, 0);           // R4
        step(4, 0, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0, 0);           // R4 overflow
        step(6, 0, 0, 0, 0, 0);           // R7 mark
        step(0, 0, 0, 1, 4, 5);
        step(4, 0, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0, 0);
        step(2, 0, 4, 0, 0, 0);           // R6 at stack pointer
        step(3, 0, 5, 0, 0, 0);           // R6 above stack pointer
        step(0, 0, 0, 1, 3, 2);           // data limit = 2
        step(3, 0, 1, 0, 0, 0);           // R6 below data limit
        step(5, 0, 0, 0, 0, 0);           // R5 pop
        step(7, 0, 0, 0, 0, 0);           // R8 return
        step(5, 0, 0, 0, 0, 0);           // R5 pop at marker
        step(5, 0, 0, 0, 0, 0);           // R5 underflow below marker
        step(0, 0, 0, 1, 5, 16'hFFFF);
        step(0, 0, 0, 1, 4, 16'hFFFF);
        step(4, 0, 0, 0, 0, 0);           // R4 no wrap at top
        step(4, 0, 0, 1, 7, 0);           // R2 code 7 loads nothing, op ignored
        step(0, 0, 0, 1, 6, 0);
        step(0, 0, 0, 1, 2, 0);
        step(0, 0, 0, 1, 5, 0);
        step(5, 0, 0, 0, 0, 0);           // R5 pop from zero wraps
        for (int i = 0; i < 4000; i++) begin
            bit hw = ($urandom_range(0, 3) == 0);
            step($urandom_range(0, 7), pick(), pick(), hw, $urandom_range(0, 7), pick());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule